// File: doc/BRIEF.md
# Dual Byte Queue Controller for a Packet Radio

This block keeps two separate 128-byte queues for a packet radio. One carries transmit data and one carries receive data. The host pushes bytes into the transmit queue, and the radio datapath pops them out. The radio datapath pushes received bytes into the receive queue, and the host pops them. Each queue has a threshold flag and sticky error flags for a push when full and a pop when empty. Each queue also has a small saturating status count. A single 7-bit threshold setting serves both queues, but it is read in opposite directions for each, so that the overflow and underflow margins come out equal.

A direct-access port selects one queue at a time. Through it, firmware can read or overwrite any stored byte and can read or rewrite both pointers. Rewinding the transmit read pointer makes the radio side send a stored packet again. Patching one byte before the rewind changes only that byte of the packet.

Each queue tracks its fill with a state register that has three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. Reset and flush force `ST_EMPTY`. In every other cycle the next state is classified from the next pointer values:
- `ST_EMPTY` moves to `ST_PARTIAL` on a push.
- `ST_PARTIAL` moves to `ST_FULL` when the count reaches 128.
- `ST_PARTIAL` moves to `ST_EMPTY` when the count reaches 0.
- `ST_FULL` moves to `ST_PARTIAL` on a pop.
- A direct pointer rewrite can move from any state to any state.

Top module: `pfp_fifo_pair`

## Requirements
- R1: Each queue returns bytes in push order. A pop loads the byte at the read pointer into the read-data output at the clock edge of the pop. That value is held until the next successful pop.
- R2: The receive threshold flag is high exactly when the receive count is at least T+1, where T is the 7-bit threshold setting.
- R3: The transmit threshold flag is high exactly when the transmit count is at least 127−T. With T=127 it is always high.
- R4: The receive status equals min(receive count, 15). The transmit status equals min(128 − transmit count, 15).
- R5: A push into a full queue stores nothing and leaves the write pointer unchanged. It sets that queue's overflow flag, which stays set until a flush.
- R6: A pop from an empty queue leaves the read pointer and the read-data output unchanged. It sets that queue's underflow flag, which stays set until a flush.
- R7: `da_sel_tx` selects the transmit queue (1) or the receive queue (0). `da_rdata` shows the stored byte at `da_addr` of the selected queue in the same cycle. `da_mem_we` overwrites that byte in the selected queue only.
- R8: Pointers are 8 bits wide: bits 6:0 hold the address and bit 7 is a wrap bit. The count is the write pointer minus the read pointer. A pointer rewrite takes effect at the next edge. In that cycle it overrides any push or pop on the same queue, and the push or pop is ignored. The count, flags and status follow from the new pointers.
- R9: After the transmit read pointer is rewound to the start of a packet already sent, later pops return the same bytes again.
- R10: A flush clears that queue's pointers, overflow flag and underflow flag at the next edge.
- R11: After reset, both pointers of both queues are 0, all error flags are 0, and the receive status is 0. The transmit status is 15, and each threshold flag follows R2 and R3 for a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_set | input | 7 | Shared threshold setting T |
| tx_wr_en | input | 1 | Host push into transmit queue |
| tx_wr_data | input | 8 | Host push byte |
| tx_rd_en | input | 1 | Radio pop from transmit queue |
| tx_rd_data | output | 8 | Last byte popped from transmit queue |
| tx_flush | input | 1 | Clear transmit pointers and flags |
| rx_wr_en | input | 1 | Radio push into receive queue |
| rx_wr_data | input | 8 | Radio push byte |
| rx_rd_en | input | 1 | Host pop from receive queue |
| rx_rd_data | output | 8 | Last byte popped from receive queue |
| rx_flush | input | 1 | Clear receive pointers and flags |
| tx_thr | output | 1 | Transmit threshold flag |
| rx_thr | output | 1 | Receive threshold flag |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_unf | output | 1 | Sticky receive underflow |
| rx_avail | output | 4 | Saturated bytes in receive queue |
| tx_free | output | 4 | Saturated free bytes in transmit queue |
| da_sel_tx | input | 1 | Direct access selects transmit (1) or receive (0) |
| da_addr | input | 7 | Direct storage address |
| da_mem_we | input | 1 | Direct storage write strobe |
| da_wdata | input | 8 | Direct storage write byte |
| da_rdata | output | 8 | Stored byte at da_addr of selected queue |
| da_rptr_we | input | 1 | Rewrite read pointer of selected queue |
| da_wptr_we | input | 1 | Rewrite write pointer of selected queue |
| da_ptr_wdata | input | 8 | New pointer value, bit 7 is the wrap bit |
| da_rptr | output | 8 | Read pointer of selected queue |
| da_wptr | output | 8 | Write pointer of selected queue |

## Verification
The hardest cases to reach are the full-queue edge and the packet resend. Overflow needs all 128 transmit entries occupied, so the stimulus pushes 114 bytes to check the status just below saturation and then fills the queue completely. Only after that does it attempt one extra push. The resend path needs data that the radio side has already consumed, so the stimulus pops a short packet and then patches one stored byte through the direct port. It then rewinds the read pointer and pops the packet again, comparing it byte by byte against the patched copy.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_st_e;

    // Map a byte count onto a fill state.
    function automatic fill_st_e classify(input logic [15:0] cnt, input int unsigned depth);
        if (cnt == 16'd0)
            return ST_EMPTY;
        else if (32'(cnt) >= depth)
            return ST_FULL;
        else
            return ST_PARTIAL;
    endfunction

endpackage

// File: rtl/pfp_fifo_core.sv
module pfp_fifo_core
    import pfp_pkg::*;
#(
    parameter int DEPTH = 128,           // must be a power of two
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] mem_rdata,
    input  logic          rptr_we,
    input  logic          wptr_we,
    input  logic [PW-1:0] ptr_wdata,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] count,
    output logic          ovf,
    output logic          unf
);

    fill_st_e      state, state_n;
    logic [PW-1:0] rptr_n, wptr_n;
    logic          do_push, do_pop, set_ovf, set_unf;
    logic [DW-1:0] mem [DEPTH];

    assign count     = wptr - rptr;
    assign mem_rdata = mem[mem_addr];

    // Next pointers and fill state.
    always_comb begin
        rptr_n  = rptr;
        wptr_n  = wptr;
        do_push = 1'b0;
        do_pop  = 1'b0;
        set_ovf = 1'b0;
        set_unf = 1'b0;
        if (!flush && !rptr_we && !wptr_we) begin
            if (push) begin
                if (state != ST_FULL) begin
                    do_push = 1'b1;
                    wptr_n  = wptr + 1'b1;
                end else begin
                    set_ovf = 1'b1;
                end
            end
            if (pop) begin
                if (state != ST_EMPTY) begin
                    do_pop = 1'b1;
                    rptr_n = rptr + 1'b1;
                end else begin
                    set_unf = 1'b1;
                end
            end
        end
        if (rptr_we) rptr_n = ptr_wdata;
        if (wptr_we) wptr_n = ptr_wdata;
        if (flush) begin
            rptr_n = '0;
            wptr_n = '0;
        end
        state_n = classify(16'(wptr_n - rptr_n), DEPTH);
    end

    // State register with the pointers it is classified from.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            rptr  <= '0;
            wptr  <= '0;
        end else begin
            state <= state_n;
            rptr  <= rptr_n;
            wptr  <= wptr_n;
        end
    end

    // Outputs: read data and sticky flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_data <= '0;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            if (do_pop) pop_data <= mem[rptr[AW-1:0]];
            if (flush) begin
                ovf <= 1'b0;
                unf <= 1'b0;
            end else begin
                if (set_ovf) ovf <= 1'b1;
                if (set_unf) unf <= 1'b1;
            end
        end
    end

    // Storage; a direct write wins over a push to the same address.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[AW-1:0]] <= push_data;
        if (mem_we)  mem[mem_addr]     <= mem_wdata;
    end

    // R8: the fill state register agrees with the pointer difference
    a_r8_state_tracks_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EMPTY) == (count == '0)) &&
        ((state == ST_FULL)  == (32'(count) >= DEPTH)));

    a_r5_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state == ST_FULL && !flush && !rptr_we && !wptr_we)
        |=> (ovf && $stable(wptr)));

    a_r6_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state == ST_EMPTY && !flush && !rptr_we && !wptr_we)
        |=> (unf && $stable(rptr) && $stable(pop_data)));

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rptr == '0 && wptr == '0 && !ovf && !unf));

    a_r8_rptr_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_we && !flush) |=> (rptr == $past(ptr_wdata)));

endmodule

// File: rtl/pfp_level.sv
module pfp_level #(
    parameter int DEPTH   = 128,
    parameter int SAT     = 15,
    parameter bit TX_SIDE = 1'b0,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1,
    localparam int SW     = $clog2(SAT + 1)
) (
    input  logic [PW-1:0] count,
    input  logic [AW-1:0] thr_set,
    output logic          thr_hit,
    output logic [SW-1:0] status
);

    int cnt_i, lvl_i, raw_i;

    generate
        if (TX_SIDE) begin : g_tx
            // Threshold counts down from DEPTH-1; status reports free room.
            always_comb begin
                cnt_i = int'(count);
                lvl_i = DEPTH - 1 - int'(thr_set);
                raw_i = (cnt_i >= DEPTH) ? 0 : DEPTH - cnt_i;
            end
        end else begin : g_rx
            // Threshold counts up from 1; status reports stored bytes.
            always_comb begin
                cnt_i = int'(count);
                lvl_i = int'(thr_set) + 1;
                raw_i = cnt_i;
            end
        end
    endgenerate

    assign thr_hit = (cnt_i >= lvl_i);
    assign status  = SW'((raw_i > SAT) ? SAT : raw_i);

endmodule

// File: rtl/pfp_fifo_pair.sv
module pfp_fifo_pair #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int SAT   = 15,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int SW   = $clog2(SAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] thr_set,
    input  logic          tx_wr_en,
    input  logic [DW-1:0] tx_wr_data,
    input  logic          tx_rd_en,
    output logic [DW-1:0] tx_rd_data,
    input  logic          tx_flush,
    input  logic          rx_wr_en,
    input  logic [DW-1:0] rx_wr_data,
    input  logic          rx_rd_en,
    output logic [DW-1:0] rx_rd_data,
    input  logic          rx_flush,
    output logic          tx_thr,
    output logic          rx_thr,
    output logic          tx_ovf,
    output logic          tx_unf,
    output logic          rx_ovf,
    output logic          rx_unf,
    output logic [SW-1:0] rx_avail,
    output logic [SW-1:0] tx_free,
    input  logic          da_sel_tx,
    input  logic [AW-1:0] da_addr,
    input  logic          da_mem_we,
    input  logic [DW-1:0] da_wdata,
    output logic [DW-1:0] da_rdata,
    input  logic          da_rptr_we,
    input  logic          da_wptr_we,
    input  logic [PW-1:0] da_ptr_wdata,
    output logic [PW-1:0] da_rptr,
    output logic [PW-1:0] da_wptr
);

    logic [PW-1:0] tx_rptr, tx_wptr, tx_count;
    logic [PW-1:0] rx_rptr, rx_wptr, rx_count;
    logic [DW-1:0] tx_mrd, rx_mrd;

    pfp_fifo_core #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_rd_en),
        .pop_data  (tx_rd_data),
        .mem_we    (da_mem_we && da_sel_tx),
        .mem_addr  (da_addr),
        .mem_wdata (da_wdata),
        .mem_rdata (tx_mrd),
        .rptr_we   (da_rptr_we && da_sel_tx),
        .wptr_we   (da_wptr_we && da_sel_tx),
        .ptr_wdata (da_ptr_wdata),
        .rptr      (tx_rptr),
        .wptr      (tx_wptr),
        .count     (tx_count),
        .ovf       (tx_ovf),
        .unf       (tx_unf)
    );

    pfp_fifo_core #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_wr_en),
        .push_data (rx_wr_data),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .mem_we    (da_mem_we && !da_sel_tx),
        .mem_addr  (da_addr),
        .mem_wdata (da_wdata),
        .mem_rdata (rx_mrd),
        .rptr_we   (da_rptr_we && !da_sel_tx),
        .wptr_we   (da_wptr_we && !da_sel_tx),
        .ptr_wdata (da_ptr_wdata),
        .rptr      (rx_rptr),
        .wptr      (rx_wptr),
        .count     (rx_count),
        .ovf       (rx_ovf),
        .unf       (rx_unf)
    );

    pfp_level #(.DEPTH(DEPTH), .SAT(SAT), .TX_SIDE(1'b1)) u_txlvl (
        .count   (tx_count),
        .thr_set (thr_set),
        .thr_hit (tx_thr),
        .status  (tx_free)
    );

    pfp_level #(.DEPTH(DEPTH), .SAT(SAT), .TX_SIDE(1'b0)) u_rxlvl (
        .count   (rx_count),
        .thr_set (thr_set),
        .thr_hit (rx_thr),
        .status  (rx_avail)
    );

    assign da_rdata = da_sel_tx ? tx_mrd  : rx_mrd;
    assign da_rptr  = da_sel_tx ? tx_rptr : rx_rptr;
    assign da_wptr  = da_sel_tx ? tx_wptr : rx_wptr;

    // R4: receive status never reports more than stored or more than SAT
    a_r4_rx_status_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_avail) <= SAT) && (32'(rx_avail) <= 32'(rx_count)));

    // R2: receive threshold flag never set while the queue is empty
    a_r2_rx_thr_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_thr);

endmodule

// File: tb/tb_pfp_fifo_pair.sv
module tb_pfp_fifo_pair;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] thr_set = '0;
    logic       tx_wr_en = 0, tx_rd_en = 0, tx_flush = 0;
    logic       rx_wr_en = 0, rx_rd_en = 0, rx_flush = 0;
    logic [7:0] tx_wr_data = '0, rx_wr_data = '0;
    logic [7:0] tx_rd_data, rx_rd_data;
    logic       tx_thr, rx_thr, tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [3:0] rx_avail, tx_free;
    logic       da_sel_tx = 0, da_mem_we = 0, da_rptr_we = 0, da_wptr_we = 0;
    logic [6:0] da_addr = '0;
    logic [7:0] da_wdata = '0, da_ptr_wdata = '0;
    logic [7:0] da_rdata, da_rptr, da_wptr;

    int total = 0;
    int bad   = 0;

    // {T, expected rx_thr, expected tx_thr} with 10 bytes in each queue
    localparam logic [8:0] VEC [6] = '{
        {7'd0,   1'b1, 1'b0},
        {7'd9,   1'b1, 1'b0},
        {7'd10,  1'b0, 1'b0},
        {7'd116, 1'b0, 1'b0},
        {7'd117, 1'b0, 1'b1},
        {7'd127, 1'b0, 1'b1}
    };

    pfp_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .thr_set(thr_set),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en),
        .tx_rd_data(tx_rd_data), .tx_flush(tx_flush),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .rx_flush(rx_flush),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_ovf(rx_ovf), .rx_unf(rx_unf), .rx_avail(rx_avail), .tx_free(tx_free),
        .da_sel_tx(da_sel_tx), .da_addr(da_addr), .da_mem_we(da_mem_we),
        .da_wdata(da_wdata), .da_rdata(da_rdata), .da_rptr_we(da_rptr_we),
        .da_wptr_we(da_wptr_we), .da_ptr_wdata(da_ptr_wdata),
        .da_rptr(da_rptr), .da_wptr(da_wptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_wr_en = 1; tx_wr_data = b;
        @(negedge clk);
        tx_wr_en = 0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_wr_en = 1; rx_wr_data = b;
        @(negedge clk);
        rx_wr_en = 0;
    endtask

    task automatic pop_tx;
        tx_rd_en = 1;
        @(negedge clk);
        tx_rd_en = 0;
    endtask

    task automatic pop_rx;
        rx_rd_en = 1;
        @(negedge clk);
        rx_rd_en = 0;
    endtask

    task automatic set_tx_rptr(input logic [7:0] p);
        da_sel_tx = 1; da_ptr_wdata = p; da_rptr_we = 1;
        @(negedge clk);
        da_rptr_we = 0;
    endtask

    task automatic flush_tx;
        tx_flush = 1;
        @(negedge clk);
        tx_flush = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: reset state
        chk("R11 rx_avail", rx_avail, 0);
        chk("R11 tx_free", tx_free, 15);
        chk("R11 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
        chk("R11 thr", {rx_thr, tx_thr}, 0);
        chk("R11 rx ptrs", {da_rptr, da_wptr}, 0);

        for (int i = 0; i < 10; i++) begin
            push_tx(8'h10 + 8'(i));
            push_rx(8'h20 + 8'(i));
        end

        // R2 / R3: threshold vector walk
        for (int i = 0; i < 6; i++) begin
            thr_set = VEC[i][8:2];
            @(negedge clk);
            chk("R2 rx_thr", rx_thr, VEC[i][1]);
            chk("R3 tx_thr", tx_thr, VEC[i][0]);
        end
        chk("R4 rx_avail 10", rx_avail, 10);
        chk("R4 tx_free sat", tx_free, 15);

        // R1: receive order
        for (int i = 0; i < 10; i++) begin
            pop_rx();
            chk("R1 rx order", rx_rd_data, 8'h20 + 8'(i));
        end
        chk("R1 rx drained", rx_avail, 0);

        // R6: pop from empty
        pop_rx();
        chk("R6 data held", rx_rd_data, 8'h29);
        chk("R6 unf set", rx_unf, 1);
        chk("R6 rptr held", da_rptr, 8'd10);
        @(negedge clk);
        chk("R6 unf sticky", rx_unf, 1);

        // R10: receive flush
        rx_flush = 1;
        @(negedge clk);
        rx_flush = 0;
        chk("R10 rx flags", {rx_unf, rx_ovf}, 0);
        chk("R10 rx ptrs", {da_rptr, da_wptr}, 0);

        // R9: send four, rewind, resend
        for (int i = 0; i < 4; i++) begin
            pop_tx();
            chk("R1 tx order", tx_rd_data, 8'h10 + 8'(i));
        end
        set_tx_rptr(8'd0);
        chk("R9 rptr rewound", da_rptr, 0);
        for (int i = 0; i < 4; i++) begin
            pop_tx();
            chk("R9 resend", tx_rd_data, 8'h10 + 8'(i));
        end

        // R7: patch byte 2 of transmit only
        da_sel_tx = 1; da_addr = 7'd2; da_wdata = 8'h55; da_mem_we = 1;
        @(negedge clk);
        da_mem_we = 0;
        chk("R7 tx patched", da_rdata, 8'h55);
        da_sel_tx = 0;
        #1;
        chk("R7 rx untouched", da_rdata, 8'h22);
        set_tx_rptr(8'd0);
        for (int i = 0; i < 4; i++) begin
            pop_tx();
            chk("R7 patched resend", tx_rd_data, (i == 2) ? 8'h55 : 8'h10 + 8'(i));
        end

        // R8: pointer rewrite beats a pop in the same cycle
        da_sel_tx = 1; da_ptr_wdata = 8'd5; da_rptr_we = 1; tx_rd_en = 1;
        @(negedge clk);
        da_rptr_we = 0; tx_rd_en = 0;
        chk("R8 rptr written", da_rptr, 5);
        chk("R8 pop ignored", tx_rd_data, 8'h13);
        thr_set = 7'd122;   // level 5, count 10-5=5
        @(negedge clk);
        chk("R8 count follows", tx_thr, 1);
        thr_set = 7'd121;   // level 6
        @(negedge clk);
        chk("R8 count exact", tx_thr, 0);

        // R4 / R5: fill transmit queue
        flush_tx();
        chk("R10 tx flush", {da_rptr, da_wptr}, 0);
        for (int i = 0; i < 114; i++) push_tx(8'(i));
        chk("R4 tx_free 14", tx_free, 14);
        for (int i = 114; i < 128; i++) push_tx(8'(i));
        chk("R4 tx_free 0", tx_free, 0);
        chk("R5 no ovf yet", tx_ovf, 0);
        push_tx(8'hEE);
        chk("R5 ovf set", tx_ovf, 1);
        chk("R5 wptr held", da_wptr, 8'h80);
        pop_tx();
        chk("R5 head intact", tx_rd_data, 8'h00);
        chk("R5 ovf sticky", tx_ovf, 1);
        flush_tx();
        chk("R10 tx ovf cleared", tx_ovf, 0);
        chk("R10 tx_free", tx_free, 15);

        // R4: receive saturation
        for (int i = 0; i < 20; i++) push_rx(8'(i));
        chk("R4 rx_avail sat", rx_avail, 15);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule